// File: doc/BRIEF.md
# Indirect-Access Codec Register Block

This block is the control-register front end of an audio codec on a simple word-addressed bus. A small byte window is split into sixteen 32-bit direct registers. One direct register holds a pointer, and a second one serves as a window onto a bank of thirty-two 8-bit indirect registers. Software first writes the pointer, then reads or writes the window to reach the indirect register the pointer selects.

Several indirect slots follow special rules. One slot is write-only and always reads as zero. Two slots are read-only, and one of them holds a chip version code. Another slot keeps a fixed revision code and accepts software writes to a single bit only. A control register has a bit that restores every register to its reset value in one cycle. The interrupt output is present for the surrounding fabric but is never raised.

Top module: `codec_regblk`

## Requirements
- R1: Byte address bits [5:2] pick one of 16 direct registers, and address bits [1:0] are ignored. Direct registers 0, 3 and 5 to 15 store a written 32-bit word unchanged and read it back.
- R2: The low 5 bits of direct register 0 form the pointer. Changing the pointer changes which indirect register a read of direct register 1 returns.
- R3: A write to direct register 1 (byte address 0x04) stores wdata[7:0] into the indirect register selected by the pointer. A read of direct register 1 returns that indirect register in bits [7:0], with bits [31:8] zero.
- R4: A read through the window while the pointer is 3 returns zero, whatever was written there.
- R5: Window writes while the pointer is 11 or 25 leave those indirect registers unchanged.
- R6: A window write while the pointer is 12 stores (wdata[7:0] & 0x40) | 0x8A.
- R7: After hardware reset (rst_n low), every direct and indirect register is zero, except indirect 12, which is 0x8A, and indirect 25, which is 0xA0.
- R8: Direct register 2 ignores writes and always reads zero.
- R9: A write to direct register 4 stores wdata & 0x7F.
- R10: A write to direct register 4 with wdata[0] set returns every other register, including the pointer, to its R7 reset value. Direct register 4 itself then holds wdata & 0x7F.
- R11: irq is low at all times.
- R12: bus_rdata carries the read data in the same cycle as a read (bus_valid high, bus_we low), and it is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request, held low |

## Verification
The bench builds the block with its default parameters: a 6-bit byte address, a 5-bit pointer, 8-bit indirect registers, and the special slots at indices 3, 11, 12 and 25 with control register 4. With these values, every one of the 32 indirect slots can be reached from the pointer, so each special index can be exercised through the window next to an ordinary one (index 7). The same values also let a soft reset be checked against both version codes and against the cleared pointer.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

   typedef enum logic [1:0] {
      ACC_RW  = 2'd0,
      ACC_RO  = 2'd1,
      ACC_WO  = 2'd2,
      ACC_VER = 2'd3
   } ind_acc_e;

   // Access class of one indirect slot, resolved at elaboration.
   function automatic ind_acc_e ind_access(input int idx, input int wo_idx,
                                           input int ro_a, input int ro_b,
                                           input int ver_idx);
      if (idx == wo_idx)                  return ACC_WO;
      if (idx == ro_a || idx == ro_b)     return ACC_RO;
      if (idx == ver_idx)                 return ACC_VER;
      return ACC_RW;
   endfunction

endpackage

// File: rtl/codec_dir_regs.sv
module codec_dir_regs #(
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 4,
   parameter int NUM_DIR  = 16,
   parameter int IDX_REG  = 0,
   parameter int DATA_REG = 1,
   parameter int RO_REG   = 2,
   parameter int CTL_REG  = 4,
   parameter logic [31:0] CTL_MASK = 32'h0000_007F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              soft_rst,
   output logic [DATA_W-1:0] dir_q [NUM_DIR]
);

   localparam logic [SEL_W-1:0]  CTL_SEL = SEL_W'(CTL_REG);
   localparam logic [DATA_W-1:0] CMASK   = DATA_W'(CTL_MASK);

   // A control write with bit 0 set restores all other registers.
   assign soft_rst = wr_en && (wr_sel == CTL_SEL) && wr_data[0];

   for (genvar i = 0; i < NUM_DIR; i++) begin : g_dir
      localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
      logic hit;
      assign hit = wr_en && (wr_sel == MY_SEL);

      if (i == DATA_REG || i == RO_REG) begin : g_none
         // Window slot has no storage; read-only slot stays zero.
         assign dir_q[i] = '0;
      end else if (i == CTL_REG) begin : g_ctl
         always_ff @(posedge clk) begin
            if (!rst_n)   dir_q[i] <= '0;
            else if (hit) dir_q[i] <= wr_data & CMASK;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)        dir_q[i] <= '0;
            else if (soft_rst) dir_q[i] <= '0;
            else if (hit)      dir_q[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/codec_ind_regs.sv
module codec_ind_regs #(
   parameter int IDX_W     = 5,
   parameter int IND_W     = 8,
   parameter int NUM_IND   = 32,
   parameter int WO_IDX    = 3,
   parameter int RO_IDX_A  = 11,
   parameter int RO_IDX_B  = 25,
   parameter int VER_IDX   = 12,
   parameter logic [7:0] VER_CODE  = 8'h8A,
   parameter logic [7:0] CHIP_VER  = 8'hA0,
   parameter logic [7:0] VER_KEEP  = 8'h40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IND_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [IND_W-1:0] rd_data,
   output logic [IND_W-1:0] ind_q [NUM_IND]
);

   import codec_reg_pkg::*;

   localparam logic [IDX_W-1:0] WO_SEL = IDX_W'(WO_IDX);
   localparam logic [IND_W-1:0] VCODE  = IND_W'(VER_CODE);
   localparam logic [IND_W-1:0] VKEEP  = IND_W'(VER_KEEP);
   localparam logic [IND_W-1:0] CVER   = IND_W'(CHIP_VER);

   for (genvar i = 0; i < NUM_IND; i++) begin : g_ind
      localparam ind_acc_e ACC = ind_access(i, WO_IDX, RO_IDX_A, RO_IDX_B, VER_IDX);
      localparam logic [IND_W-1:0] RST_VAL =
         (i == VER_IDX)  ? VCODE :
         (i == RO_IDX_B) ? CVER  : '0;
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      logic hit;
      assign hit = wr_en && (wr_idx == MY_IDX);

      if (ACC == ACC_RO) begin : g_ro
         always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) ind_q[i] <= RST_VAL;
         end
      end else if (ACC == ACC_VER) begin : g_ver
         always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) ind_q[i] <= RST_VAL;
            else if (hit)           ind_q[i] <= (wr_data & VKEEP) | VCODE;
         end
      end else begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) ind_q[i] <= RST_VAL;
            else if (hit)           ind_q[i] <= wr_data;
         end
      end
   end

   // Write-only slot hides its content on reads.
   assign rd_data = (rd_idx == WO_SEL) ? '0 : ind_q[rd_idx];

endmodule

// File: rtl/codec_regblk.sv
module codec_regblk #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 5,
   parameter int IND_W    = 8,
   parameter int IDX_REG  = 0,
   parameter int DATA_REG = 1,
   parameter int RO_REG   = 2,
   parameter int CTL_REG  = 4,
   parameter logic [31:0] CTL_MASK = 32'h0000_007F,
   parameter int WO_IDX   = 3,
   parameter int RO_IDX_A = 11,
   parameter int RO_IDX_B = 25,
   parameter int VER_IDX  = 12,
   parameter logic [7:0] VER_CODE = 8'h8A,
   parameter logic [7:0] CHIP_VER = 8'hA0,
   parameter logic [7:0] VER_KEEP = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int SEL_W   = ADDR_W - 2;
   localparam int NUM_DIR = 1 << SEL_W;
   localparam int NUM_IND = 1 << IDX_W;
   localparam logic [SEL_W-1:0] DATA_SEL = SEL_W'(DATA_REG);

   // Elaboration-time parameter checks
   if (ADDR_W < 3)
      begin : g_chk_addr  $error("ADDR_W must leave at least one select bit"); end
   if (IDX_W > DATA_W || IND_W > DATA_W || IND_W < 8)
      begin : g_chk_width $error("pointer or indirect width does not fit the data bus"); end
   if (IDX_REG >= NUM_DIR || DATA_REG >= NUM_DIR || RO_REG >= NUM_DIR || CTL_REG >= NUM_DIR)
      begin : g_chk_dir   $error("direct register index outside the window"); end
   if (IDX_REG == DATA_REG || IDX_REG == CTL_REG || DATA_REG == CTL_REG ||
       RO_REG == IDX_REG || RO_REG == DATA_REG || RO_REG == CTL_REG)
      begin : g_chk_uniq  $error("direct register roles must be distinct"); end
   if (WO_IDX >= NUM_IND || RO_IDX_A >= NUM_IND || RO_IDX_B >= NUM_IND || VER_IDX >= NUM_IND)
      begin : g_chk_ind   $error("special indirect index outside the bank"); end

   logic              wr_en;
   logic [SEL_W-1:0]  sel;
   logic              soft_rst;
   logic [DATA_W-1:0] dir_q [NUM_DIR];
   logic [IND_W-1:0]  ind_q [NUM_IND];
   logic [IDX_W-1:0]  cur_idx;
   logic [IND_W-1:0]  ind_rd;
   logic [DATA_W-1:0] ctl_q;

   assign wr_en   = bus_valid && bus_we;
   assign sel     = bus_addr[ADDR_W-1:2];
   assign cur_idx = dir_q[IDX_REG][IDX_W-1:0];
   assign ctl_q   = dir_q[CTL_REG];

   codec_dir_regs #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_DIR(NUM_DIR),
      .IDX_REG(IDX_REG), .DATA_REG(DATA_REG), .RO_REG(RO_REG),
      .CTL_REG(CTL_REG), .CTL_MASK(CTL_MASK)
   ) u_dir (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel),
      .wr_data(bus_wdata), .soft_rst(soft_rst), .dir_q(dir_q)
   );

   codec_ind_regs #(
      .IDX_W(IDX_W), .IND_W(IND_W), .NUM_IND(NUM_IND),
      .WO_IDX(WO_IDX), .RO_IDX_A(RO_IDX_A), .RO_IDX_B(RO_IDX_B),
      .VER_IDX(VER_IDX), .VER_CODE(VER_CODE), .CHIP_VER(CHIP_VER),
      .VER_KEEP(VER_KEEP)
   ) u_ind (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en && (sel == DATA_SEL)), .wr_idx(cur_idx),
      .wr_data(bus_wdata[IND_W-1:0]), .rd_idx(cur_idx),
      .rd_data(ind_rd), .ind_q(ind_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_we) begin
         if (sel == DATA_SEL) bus_rdata = DATA_W'(ind_rd);
         else                 bus_rdata = dir_q[sel];
      end
   end

   assign irq = 1'b0;

endmodule

// File: rtl/codec_regblk_chk.sv
module codec_regblk_chk #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 5,
   parameter int IND_W    = 8,
   parameter int DATA_REG = 1,
   parameter int CTL_REG  = 4,
   parameter logic [31:0] CTL_MASK = 32'h0000_007F,
   parameter int WO_IDX   = 3,
   parameter int RO_IDX_B = 25,
   parameter logic [7:0] VER_CODE = 8'h8A,
   parameter logic [7:0] VER_KEEP = 8'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [IND_W-1:0]  ver_byte,
   input logic [IND_W-1:0]  rob_byte,
   input logic [DATA_W-1:0] ctl_q
);

   localparam int SEL_W = ADDR_W - 2;
   logic [SEL_W-1:0] sel;
   assign sel = bus_addr[ADDR_W-1:2];

   a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && sel == SEL_W'(DATA_REG) && cur_idx == IDX_W'(WO_IDX))
      |-> (bus_rdata == '0));

   a_r5_ro_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we && sel == SEL_W'(DATA_REG) && cur_idx == IDX_W'(RO_IDX_B))
      |=> $stable(rob_byte));

   a_r6_ver_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (ver_byte & IND_W'(VER_CODE)) == IND_W'(VER_CODE));

   a_r6_ver_only_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (ver_byte & ~IND_W'(VER_CODE | VER_KEEP)) == '0);

   a_r9_ctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we && sel == SEL_W'(CTL_REG))
      |=> (ctl_q == ($past(bus_wdata) & DATA_W'(CTL_MASK))));

   a_r10_soft_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we && sel == SEL_W'(CTL_REG) && bus_wdata[0])
      |=> (cur_idx == '0));

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_we) |-> (bus_rdata == '0));

endmodule

bind codec_regblk codec_regblk_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .IND_W(IND_W),
   .DATA_REG(DATA_REG), .CTL_REG(CTL_REG), .CTL_MASK(CTL_MASK),
   .WO_IDX(WO_IDX), .RO_IDX_B(RO_IDX_B), .VER_CODE(VER_CODE), .VER_KEEP(VER_KEEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .cur_idx(cur_idx), .ver_byte(ind_q[VER_IDX]), .rob_byte(ind_q[RO_IDX_B]),
   .ctl_q(ctl_q)
);

// File: tb/test_codec_regblk.sv
`timescale 1ns/1ps
module test_codec_regblk;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   codec_regblk i_codec_regblk (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   // {we, addr[5:0], wdata[31:0], expected rdata[31:0], requirement number[3:0]}
   localparam int NV = 50;
   localparam logic [74:0] VEC [NV] = '{
      {1'b1, 6'h0C, 32'hDEADBEEF, 32'h0, 4'd1},   // R1 store direct 3
      {1'b0, 6'h0C, 32'h0, 32'hDEADBEEF, 4'd1},   // R1 read back
      {1'b0, 6'h0F, 32'h0, 32'hDEADBEEF, 4'd1},   // R1 low address bits ignored
      {1'b1, 6'h3E, 32'h12345678, 32'h0, 4'd1},   // R1 direct 15 via unaligned address
      {1'b0, 6'h3C, 32'h0, 32'h12345678, 4'd1},   // R1
      {1'b1, 6'h00, 32'hFFFFFFE7, 32'h0, 4'd2},   // R2 pointer = 7
      {1'b0, 6'h00, 32'h0, 32'hFFFFFFE7, 4'd1},   // R1 pointer register keeps 32 bits
      {1'b1, 6'h04, 32'h000001A5, 32'h0, 4'd3},   // R3 window write
      {1'b0, 6'h04, 32'h0, 32'h000000A5, 4'd3},   // R3 low byte only
      {1'b0, 6'h0C, 32'h0, 32'hDEADBEEF, 4'd3},   // R3 direct untouched
      {1'b1, 6'h00, 32'h3, 32'h0, 4'd4},          // R4 pointer = 3
      {1'b1, 6'h04, 32'h77, 32'h0, 4'd4},         // R4
      {1'b0, 6'h04, 32'h0, 32'h0, 4'd4},          // R4 write-only reads zero
      {1'b1, 6'h00, 32'h7, 32'h0, 4'd2},          // R2 back to 7
      {1'b0, 6'h04, 32'h0, 32'hA5, 4'd2},         // R2
      {1'b1, 6'h00, 32'h0B, 32'h0, 4'd5},         // R5 pointer = 11
      {1'b0, 6'h04, 32'h0, 32'h0, 4'd5},          // R5
      {1'b1, 6'h04, 32'hFF, 32'h0, 4'd5},         // R5
      {1'b0, 6'h04, 32'h0, 32'h0, 4'd5},          // R5 write dropped
      {1'b1, 6'h00, 32'h19, 32'h0, 4'd7},         // R7 pointer = 25
      {1'b0, 6'h04, 32'h0, 32'hA0, 4'd7},         // R7 chip version
      {1'b1, 6'h04, 32'h12, 32'h0, 4'd5},         // R5
      {1'b0, 6'h04, 32'h0, 32'hA0, 4'd5},         // R5 write dropped
      {1'b1, 6'h00, 32'h0C, 32'h0, 4'd6},         // R6 pointer = 12
      {1'b0, 6'h04, 32'h0, 32'h8A, 4'd7},         // R7 revision code
      {1'b1, 6'h04, 32'hFF, 32'h0, 4'd6},         // R6
      {1'b0, 6'h04, 32'h0, 32'hCA, 4'd6},         // R6 only bit 6 taken
      {1'b1, 6'h04, 32'h35, 32'h0, 4'd6},         // R6
      {1'b0, 6'h04, 32'h0, 32'h8A, 4'd6},         // R6 code bits stay
      {1'b1, 6'h08, 32'hFFFFFFFF, 32'h0, 4'd8},   // R8
      {1'b0, 6'h08, 32'h0, 32'h0, 4'd8},          // R8 read-only direct
      {1'b1, 6'h10, 32'hFFFFFF7E, 32'h0, 4'd9},   // R9 bit 0 clear
      {1'b0, 6'h10, 32'h0, 32'h7E, 4'd9},         // R9 masked
      {1'b0, 6'h00, 32'h0, 32'h0C, 4'd9},         // R9 no reset happened
      {1'b0, 6'h0C, 32'h0, 32'hDEADBEEF, 4'd9},   // R9
      {1'b1, 6'h10, 32'h00000081, 32'h0, 4'd10},  // R10 soft reset
      {1'b0, 6'h10, 32'h0, 32'h01, 4'd10},        // R10 control keeps masked value
      {1'b0, 6'h00, 32'h0, 32'h0, 4'd10},         // R10 pointer cleared
      {1'b0, 6'h0C, 32'h0, 32'h0, 4'd10},         // R10 direct cleared
      {1'b1, 6'h00, 32'h7, 32'h0, 4'd10},         // R10
      {1'b0, 6'h04, 32'h0, 32'h0, 4'd10},         // R10 indirect 7 cleared
      {1'b1, 6'h00, 32'h19, 32'h0, 4'd10},        // R10
      {1'b0, 6'h04, 32'h0, 32'hA0, 4'd10},        // R10 chip version reloaded
      {1'b1, 6'h00, 32'h0C, 32'h0, 4'd10},        // R10
      {1'b0, 6'h04, 32'h0, 32'h8A, 4'd10},        // R10 revision reloaded
      {1'b1, 6'h04, 32'hFF, 32'h0, 4'd6},         // R6
      {1'b0, 6'h04, 32'h0, 32'hCA, 4'd6},         // R6
      {1'b1, 6'h10, 32'h00000001, 32'h0, 4'd10},  // R10 second soft reset
      {1'b1, 6'h00, 32'h0C, 32'h0, 4'd10},        // R10
      {1'b0, 6'h04, 32'h0, 32'h8A, 4'd10}         // R10 bit 6 cleared again
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Drive at negedge, sample reads 1 ns later, writes commit at the next posedge.
   task automatic bus_op(input logic we, input logic [5:0] addr, input logic [31:0] wd,
                         input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_valid = 1'b1;
      bus_we    = we;
      bus_addr  = addr;
      bus_wdata = wd;
      #1;
      if (!we) check(req, bus_rdata, exp);
      check("R11", {31'b0, irq}, 32'h0);
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      bus_valid = 1'b0;
      bus_we    = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state
      bus_op(1'b0, 6'h00, 32'h0, 32'h0, "R7");
      bus_op(1'b0, 6'h04, 32'h0, 32'h0, "R7");
      bus_op(1'b0, 6'h3C, 32'h0, 32'h0, "R7");
      bus_op(1'b0, 6'h10, 32'h0, 32'h0, "R7");

      for (int k = 0; k < NV; k++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[k][3:0]);
         bus_op(VEC[k][74], VEC[k][73:68], VEC[k][67:36], VEC[k][35:4], tag);
      end

      // R12: no read strobe means zero read data, even with a valid address
      bus_op(1'b1, 6'h0C, 32'hCAFEF00D, 32'h0, "R12");
      idle();
      bus_addr = 6'h0C;
      #1 check("R12", bus_rdata, 32'h0);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b1;
      #1 check("R12", bus_rdata, 32'h0);
      bus_valid = 1'b0; bus_we = 1'b0;
      bus_op(1'b0, 6'h0C, 32'h0, 32'hCAFEF00D, "R12");

      // R7 hardware reset mid-run
      bus_op(1'b1, 6'h00, 32'h0C, 32'h0, "R7");
      bus_op(1'b1, 6'h10, 32'h7E, 32'h0, "R7");
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      bus_op(1'b0, 6'h0C, 32'h0, 32'h0, "R7");
      bus_op(1'b0, 6'h00, 32'h0, 32'h0, "R7");
      bus_op(1'b0, 6'h10, 32'h0, 32'h0, "R7");
      bus_op(1'b1, 6'h00, 32'h0C, 32'h0, "R7");
      bus_op(1'b0, 6'h04, 32'h0, 32'h8A, "R7");
      bus_op(1'b1, 6'h00, 32'h19, 32'h0, "R7");
      bus_op(1'b0, 6'h04, 32'h0, 32'hA0, "R7");
      idle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule